// File: doc/BRIEF.md
# IO Wait-State Bridge for an 8-bit CPU Bus

This block sits on a synchronous 8-bit CPU bus and answers IO cycles on behalf of slow logic. When the CPU starts an IO read or write, the bridge pulls the wait line low in the same clock and decodes the port from the low six address bits only. It then services the access against one of several targets and releases wait once that target has answered.

The targets are a boot-image byte stream, a UART byte interface for transmit and receive, a serial-chip style status byte, and two control registers. One control register holds an interrupt vector and the other enables interrupts. A pending received byte can pull the interrupt line low. During an interrupt-acknowledge cycle the bridge puts the vector byte on the bus, as a vectored interrupt mode expects.

The boot stream fills low memory after a first-stage loader has started. Once that stream has run dry, reads of the boot port return 0xFF and raise a sticky end-of-stream flag.

Top module: `io_wait_bridge`

## Requirements
- R1: An IO cycle is `iorq_n` low with `m1_n` high and either `rd_n` or `wr_n` low. `wait_n` goes low in the same clock that the cycle becomes visible. It stays low until the target answers and rises one clock after the internal service-done pulse.
- R2: Only address bits 5..0 select a port. Addresses that differ only in bits 7..6 reach the same register, so 0xBF, 0xFF and 0x3F are all the boot port.
- R3: A read of port 0x3F returns the next boot byte and pops exactly one byte (`boot_ready` pulses for one clock while `boot_valid` is high). If no byte is ready and the stream has not ended, wait is held.
- R4: A boot-port read with `boot_valid` low and `boot_end` high returns 0xFF and sets the end-of-stream flag, which is status bit 2. The flag stays set until reset.
- R5: A write to port 0x01 produces one `tx_valid` pulse carrying the written byte. Wait is held for as long as `tx_ready` is low.
- R6: A read of port 0x01 returns `rx_data` and pulses `rx_ready` when `rx_valid` is high. Otherwise it returns 0x00 with no pop.
- R7: A read of port 0x00 returns status: bit 0 = received byte waiting, bit 1 = transmitter ready, bit 2 = end-of-stream, all other bits 0.
- R8: `cpu_doe` is high only while `iorq_n` and `rd_n` are both low with `m1_n` high, or during interrupt acknowledge (`iorq_n` and `m1_n` low). After wait is released during a read, `cpu_dout` holds the serviced byte.
- R9: `int_n` is low exactly while the interrupt-enable bit (bit 0 of port 0x03, cleared by reset) is set and `rx_valid` is high.
- R10: During interrupt acknowledge, `cpu_dout` carries the vector register. A write to port 0x02 sets it and a read returns it. Its reset value is 0xE0.
- R11: Reads of undecoded ports return 0xFF and complete without a target. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 8 | Low byte of the CPU address (IO port number) |
| cpu_din | input | 8 | Data driven by the CPU |
| cpu_dout | output | 8 | Data the bridge returns |
| cpu_doe | output | 1 | Output enable for cpu_dout |
| iorq_n | input | 1 | IO request strobe |
| rd_n | input | 1 | Read strobe |
| wr_n | input | 1 | Write strobe |
| m1_n | input | 1 | Opcode fetch / acknowledge marker |
| wait_n | output | 1 | Wait request to the CPU |
| int_n | output | 1 | Interrupt request to the CPU |
| boot_valid | input | 1 | A boot byte is available |
| boot_data | input | 8 | Current boot byte |
| boot_end | input | 1 | Boot stream exhausted |
| boot_ready | output | 1 | Pop pulse for the boot stream |
| tx_data | output | 8 | Byte handed to the UART transmitter |
| tx_valid | output | 1 | Transmit strobe |
| tx_ready | input | 1 | Transmitter can accept a byte |
| rx_data | input | 8 | Byte from the UART receiver |
| rx_valid | input | 1 | A received byte is waiting |
| rx_ready | output | 1 | Pop pulse for the receiver |

## Verification
The hardest case to reach is an IO cycle held in wait by a target that is not ready. Examples are a boot read with no byte yet, or a transmit write while the transmitter is busy. A later input change must then release wait at exactly the right edge. The stimulus reaches this state by running a bus cycle in one branch of a fork. The other branch keeps the target idle for several clocks, checks that wait is still low, and then supplies the byte or raises the ready signal. The clock-by-clock reference model in the bench judges the release edge, the pops and the returned byte. It also checks the sticky end-of-stream bit across later reads and aliased port addresses.

// File: rtl/iow_pkg.sv
`timescale 1ns/1ps
package iow_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SVC  = 2'd1,
    SQ_REL  = 2'd2
  } seq_e;

  typedef enum logic [2:0] {
    TG_STAT = 3'd0,
    TG_DATA = 3'd1,
    TG_VEC  = 3'd2,
    TG_IEN  = 3'd3,
    TG_BOOT = 3'd4,
    TG_NONE = 3'd5
  } tgt_e;

  // Status layout: bit0 rx waiting, bit1 tx ready, bit2 end of stream.
  function automatic logic [7:0] status_byte(input logic rx_w, input logic tx_r,
                                             input logic eos);
    return {5'b00000, eos, tx_r, rx_w};
  endfunction

  // A target may complete the service step in this clock.
  function automatic logic target_ready(input tgt_e t, input logic rd, input logic wr,
                                        input logic bvalid, input logic bend,
                                        input logic txr);
    logic r;
    r = 1'b1;
    if (t == TG_BOOT && rd) r = bvalid | bend;
    if (t == TG_DATA && wr) r = txr;
    return r;
  endfunction

endpackage

// File: rtl/iow_decode.sv
`timescale 1ns/1ps
module iow_decode
  import iow_pkg::*;
#(
  parameter int AW = 8,
  parameter int PW = 6,
  parameter logic [PW-1:0] P_STAT = 6'h00,
  parameter logic [PW-1:0] P_DATA = 6'h01,
  parameter logic [PW-1:0] P_VEC  = 6'h02,
  parameter logic [PW-1:0] P_IEN  = 6'h03,
  parameter logic [PW-1:0] P_BOOT = 6'h3F
) (
  input  logic [AW-1:0] addr,
  output tgt_e          tgt
);
  logic [PW-1:0] port;
  assign port = addr[PW-1:0];

  generate
    if (AW > PW) begin : g_hi
      logic addr_hi_unused;
      assign addr_hi_unused = ^addr[AW-1:PW];
    end
  endgenerate

  always_comb begin
    tgt = TG_NONE;
    if (port == P_STAT) tgt = TG_STAT;
    if (port == P_DATA) tgt = TG_DATA;
    if (port == P_VEC)  tgt = TG_VEC;
    if (port == P_IEN)  tgt = TG_IEN;
    if (port == P_BOOT) tgt = TG_BOOT;
  end
endmodule

// File: rtl/iow_seq.sv
`timescale 1ns/1ps
module iow_seq
  import iow_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic io_active,
  input  logic done_c,
  output logic wait_n,
  output logic svc_act,
  output logic svc_done
);
  seq_e st_q, st_d;

  assign svc_act  = (st_q == SQ_SVC) && io_active;
  assign svc_done = svc_act && done_c;
  assign wait_n   = !(io_active && (st_q != SQ_REL));

  always_comb begin
    st_d = st_q;
    case (st_q)
      SQ_IDLE: if (io_active) st_d = SQ_SVC;
      SQ_SVC:  if (!io_active) st_d = SQ_IDLE;
               else if (done_c) st_d = SQ_REL;
      SQ_REL:  if (!io_active) st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  // R1: wait rises one clock after the service-done pulse
  a_r1_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    svc_done |=> wait_n);
  // R1: a pending service keeps wait low while the cycle lasts
  a_r1_hold_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_act && !done_c) |=> (!wait_n || !io_active));
endmodule

// File: rtl/iow_targets.sv
`timescale 1ns/1ps
module iow_targets
  import iow_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] VEC_INIT = 8'hE0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tgt_e          tgt,
  input  logic          rd,
  input  logic          wr,
  input  logic          svc_done,
  input  logic [DW-1:0] din,
  output logic          done_c,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] vec,
  output logic          int_req,
  input  logic          boot_valid,
  input  logic [DW-1:0] boot_data,
  input  logic          boot_end,
  output logic          boot_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  output logic          rx_ready
);
  logic [DW-1:0] vec_q, rdata_q, rval_c;
  logic          ien_q, eos_q;
  logic          wr_vec, wr_ien, eos_hit;

  assign done_c = target_ready(tgt, rd, wr, boot_valid, boot_end, tx_ready);

  always_comb begin
    case (tgt)
      TG_STAT: rval_c = DW'(status_byte(rx_valid, tx_ready, eos_q));
      TG_DATA: rval_c = rx_valid ? rx_data : '0;
      TG_VEC:  rval_c = vec_q;
      TG_IEN:  rval_c = {{(DW-1){1'b0}}, ien_q};
      TG_BOOT: rval_c = boot_valid ? boot_data : '1;
      default: rval_c = '1;
    endcase
  end

  assign boot_ready = svc_done && rd && (tgt == TG_BOOT) && boot_valid;
  assign eos_hit    = svc_done && rd && (tgt == TG_BOOT) && !boot_valid;
  assign rx_ready   = svc_done && rd && (tgt == TG_DATA) && rx_valid;
  assign tx_valid   = svc_done && wr && (tgt == TG_DATA);
  assign tx_data    = din;
  assign wr_vec     = svc_done && wr && (tgt == TG_VEC);
  assign wr_ien     = svc_done && wr && (tgt == TG_IEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q   <= VEC_INIT;
      ien_q   <= 1'b0;
      eos_q   <= 1'b0;
      rdata_q <= '1;
    end else begin
      if (wr_vec) vec_q <= din;
      if (wr_ien) ien_q <= din[0];
      if (eos_hit) eos_q <= 1'b1;
      if (svc_done && rd) rdata_q <= rval_c;
    end
  end

  assign rdata   = rdata_q;
  assign vec     = vec_q;
  assign int_req = ien_q && rx_valid;

  // R3: a pop only happens when a byte is offered
  a_r3_pop_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    boot_ready |-> boot_valid);
  // R4: end-of-stream flag never clears without reset
  a_r4_eos_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    eos_q |=> eos_q);
  // R5: transmit strobe only with room in the transmitter
  a_r5_tx_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_ready);
  // R6: receive pop only with a byte waiting
  a_r6_rx_pop_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> rx_valid);
  // R3: one pop per serviced read, never two clocks in a row
  a_r3_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
    boot_ready |=> !boot_ready);
endmodule

// File: rtl/io_wait_bridge.sv
`timescale 1ns/1ps
module io_wait_bridge
  import iow_pkg::*;
#(
  parameter int AW = 8,
  parameter int PW = 6,
  parameter int DW = 8,
  parameter logic [DW-1:0] VEC_INIT = 8'hE0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_din,
  output logic [DW-1:0] cpu_dout,
  output logic          cpu_doe,
  input  logic          iorq_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          m1_n,
  output logic          wait_n,
  output logic          int_n,
  input  logic          boot_valid,
  input  logic [DW-1:0] boot_data,
  input  logic          boot_end,
  output logic          boot_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  output logic          rx_ready
);
  logic io_active, io_rd, io_wr, int_ack;
  logic done_c, svc_act, svc_done, int_req;
  logic [DW-1:0] rdata, vec;
  tgt_e tgt;

  assign io_rd     = !iorq_n && m1_n && !rd_n;
  assign io_wr     = !iorq_n && m1_n && rd_n && !wr_n;
  assign io_active = io_rd || io_wr;
  assign int_ack   = !iorq_n && !m1_n;

  iow_decode #(.AW(AW), .PW(PW)) u_dec (
    .addr(cpu_addr), .tgt(tgt)
  );

  iow_seq u_seq (
    .clk(clk), .rst_n(rst_n), .io_active(io_active), .done_c(done_c),
    .wait_n(wait_n), .svc_act(svc_act), .svc_done(svc_done)
  );

  iow_targets #(.DW(DW), .VEC_INIT(VEC_INIT)) u_tgt (
    .clk(clk), .rst_n(rst_n), .tgt(tgt), .rd(io_rd), .wr(io_wr),
    .svc_done(svc_done), .din(cpu_din), .done_c(done_c), .rdata(rdata),
    .vec(vec), .int_req(int_req),
    .boot_valid(boot_valid), .boot_data(boot_data), .boot_end(boot_end),
    .boot_ready(boot_ready), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready)
  );

  assign cpu_doe  = io_rd || int_ack;
  assign cpu_dout = int_ack ? vec : rdata;
  assign int_n    = !int_req;

  // R8: the bus is only driven inside an IO request
  a_r8_drive_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_doe |-> !iorq_n);
  // R9: interrupt only while a received byte waits
  a_r9_int_source: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |-> rx_valid);
  // R1: a write keeps wait low while the transmitter is busy
  a_r1_tx_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_act && io_wr && !tx_ready && tgt == TG_DATA) |-> !wait_n);
  // R10: acknowledge never waits
  a_r10_ack_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> wait_n);
endmodule

// File: tb/sim_io_wait_bridge.sv
`timescale 1ns/1ps
module sim_io_wait_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cpu_addr = 8'h00, cpu_din = 8'h00;
  logic [7:0] cpu_dout;
  logic cpu_doe, wait_n, int_n, boot_ready, tx_valid, rx_ready;
  logic iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
  logic boot_valid, boot_end = 1'b0, boot_en = 1'b1;
  logic [7:0] boot_data, tx_data;
  logic tx_ready = 1'b1, rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [7:0] bmem [8];
  int blen = 0;
  int bidx = 0;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done_flag = 0;

  // reference model state
  int mst = 0;
  logic [7:0] m_vec = 8'hE0, m_rdata = 8'hFF, tx_last = 8'h00;
  bit m_ien = 0, m_eos = 0;

  always #4 clk = ~clk;

  assign boot_valid = boot_en && (bidx < blen);
  assign boot_data  = (bidx < 8) ? bmem[bidx[2:0]] : 8'h00;

  io_wait_bridge u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
    .cpu_dout(cpu_dout), .cpu_doe(cpu_doe), .iorq_n(iorq_n), .rd_n(rd_n),
    .wr_n(wr_n), .m1_n(m1_n), .wait_n(wait_n), .int_n(int_n),
    .boot_valid(boot_valid), .boot_data(boot_data), .boot_end(boot_end),
    .boot_ready(boot_ready), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready)
  );

  function automatic bit m_io();
    return !iorq_n && m1_n && (!rd_n || !wr_n);
  endfunction

  function automatic bit m_done();
    int p;
    p = int'(cpu_addr) % 64;
    if (!(mst == 1 && m_io())) return 0;
    if (!rd_n) return (p == 63) ? (boot_valid || boot_end) : 1'b1;
    return (p == 1) ? tx_ready : 1'b1;
  endfunction

  function automatic logic [7:0] m_rval();
    int p;
    p = int'(cpu_addr) % 64;
    case (p)
      0: return (rx_valid ? 8'd1 : 8'd0) + (tx_ready ? 8'd2 : 8'd0) + (m_eos ? 8'd4 : 8'd0);
      1: return rx_valid ? rx_data : 8'h00;
      2: return m_vec;
      3: return m_ien ? 8'h01 : 8'h00;
      63: return boot_valid ? boot_data : 8'hFF;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
    end
  endtask

  // model update on the clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mst <= 0; m_vec <= 8'hE0; m_ien <= 0; m_eos <= 0; m_rdata <= 8'hFF; bidx <= 0;
    end else begin
      case (mst)
        0: if (m_io()) mst <= 1;
        1: if (!m_io()) mst <= 0;
           else if (m_done()) begin
             mst <= 2;
             if (!rd_n) begin
               m_rdata <= m_rval();
               if (int'(cpu_addr) % 64 == 63) begin
                 if (boot_valid) bidx <= bidx + 1;
                 else m_eos <= 1;
               end
             end else begin
               if (int'(cpu_addr) % 64 == 2) m_vec <= cpu_din;
               if (int'(cpu_addr) % 64 == 3) m_ien <= cpu_din[0];
             end
           end
        default: if (!m_io()) mst <= 0;
      endcase
    end
    if (tx_valid) tx_last <= tx_data;
  end

  // clock-by-clock comparison just before each rising edge
  always @(negedge clk) begin
    #3;
    if (rst_n && !done_flag) begin
      bit ack, dn, prd;
      int p;
      ack = !iorq_n && !m1_n;
      dn  = m_done();
      prd = !rd_n;
      p   = int'(cpu_addr) % 64;
      chk("R1 wait_n", {7'b0, wait_n}, {7'b0, !(m_io() && mst != 2)});
      chk("R8 cpu_doe", {7'b0, cpu_doe}, {7'b0, (!iorq_n && !rd_n && m1_n) || ack});
      chk("R9 int_n", {7'b0, int_n}, {7'b0, !(m_ien && rx_valid)});
      chk("R3 boot_ready", {7'b0, boot_ready}, {7'b0, dn && prd && p == 63 && boot_valid});
      chk("R5 tx_valid", {7'b0, tx_valid}, {7'b0, dn && !prd && p == 1});
      chk("R6 rx_ready", {7'b0, rx_ready}, {7'b0, dn && prd && p == 1 && rx_valid});
      if (dn && !prd && p == 1) chk("R5 tx_data", tx_data, cpu_din);
      if (ack) chk("R10 vector", cpu_dout, m_vec);
      else if (mst == 2 && prd && !iorq_n) chk("R8 read data", cpu_dout, m_rdata);
    end
  end

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      finish_up();
    end
  end

  task automatic io_read(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    cpu_addr = a; iorq_n = 0; rd_n = 0;
    do begin @(negedge clk); #1; end while (!wait_n);
    v = cpu_dout;
    @(negedge clk);
    iorq_n = 1; rd_n = 1;
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_din = d; iorq_n = 0; wr_n = 0;
    #1 chk("R8 no drive on write", {7'b0, cpu_doe}, 8'h00);
    do begin @(negedge clk); #1; end while (!wait_n);
    @(negedge clk);
    iorq_n = 1; wr_n = 1;
  endtask

  task automatic int_ack(output logic [7:0] v);
    @(negedge clk);
    m1_n = 0; iorq_n = 0;
    @(negedge clk); #1;
    v = cpu_dout;
    @(negedge clk);
    m1_n = 1; iorq_n = 1;
  endtask

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 8; i++) bmem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset wait_n", {7'b0, wait_n}, 8'h01);
    chk("R8 reset cpu_doe", {7'b0, cpu_doe}, 8'h00);
    chk("R9 reset int_n", {7'b0, int_n}, 8'h01);

    // R7 status bits
    io_read(8'h00, v); chk("R7 status idle", v, 8'h02);
    rx_valid = 1; rx_data = 8'h3C;
    io_read(8'h40, v); chk("R7 R2 status alias rx", v, 8'h03);
    rx_valid = 0;

    // R10 vector register, R2 alias
    io_read(8'h02, v); chk("R10 vector reset", v, 8'hE0);
    io_write(8'h82, 8'h5C);
    io_read(8'h02, v); chk("R10 R2 vector readback", v, 8'h5C);
    int_ack(v); chk("R10 ack vector", v, 8'h5C);

    // R11 undecoded ports
    io_write(8'h15, 8'hAA);
    io_read(8'h15, v); chk("R11 undecoded read", v, 8'hFF);
    io_read(8'h02, v); chk("R11 vector untouched", v, 8'h5C);
    io_read(8'h03, v); chk("R11 ien untouched", v, 8'h00);

    // R3 boot stream via aliases
    bmem[0] = 8'h11; bmem[1] = 8'h22; bmem[2] = 8'h33; bmem[3] = 8'h44;
    blen = 3;
    io_read(8'hFF, v); chk("R3 boot byte 0", v, 8'h11);
    io_read(8'hFF, v); chk("R3 boot byte 1", v, 8'h22);
    io_read(8'h3F, v); chk("R3 R2 boot byte 2", v, 8'h33);

    // R1 wait held while the boot stream is empty
    boot_en = 0; blen = 4;
    fork
      io_read(8'hBF, v);
      begin
        repeat (5) @(negedge clk);
        #1 chk("R1 wait held on empty stream", {7'b0, wait_n}, 8'h00);
        boot_en = 1;
      end
    join
    chk("R3 delayed boot byte", v, 8'h44);

    // R4 end of stream
    boot_end = 1;
    io_read(8'hFF, v); chk("R4 exhausted read", v, 8'hFF);
    io_read(8'h00, v); chk("R4 R7 eos status", v, 8'h06);
    boot_end = 0;
    io_read(8'hC0, v); chk("R4 eos sticky", v, 8'h06);

    // R5 transmit with stall
    tx_ready = 0;
    fork
      io_write(8'h01, 8'h41);
      begin
        repeat (4) @(negedge clk);
        #1 chk("R5 R1 wait held while tx busy", {7'b0, wait_n}, 8'h00);
        tx_ready = 1;
      end
    join
    chk("R5 tx byte", tx_last, 8'h41);
    io_write(8'h41, 8'h42);
    chk("R5 R2 tx byte via alias", tx_last, 8'h42);

    // R9 interrupt, R6 receive
    rx_valid = 1; rx_data = 8'h7E;
    #1 chk("R9 int masked", {7'b0, int_n}, 8'h01);
    io_write(8'h03, 8'h01);
    #1 chk("R9 int raised", {7'b0, int_n}, 8'h00);
    int_ack(v); chk("R10 ack during int", v, 8'h5C);
    io_read(8'hC1, v); chk("R6 rx byte", v, 8'h7E);
    rx_valid = 0;
    #1 chk("R9 int cleared", {7'b0, int_n}, 8'h01);
    io_read(8'h01, v); chk("R6 empty rx read", v, 8'h00);

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule